// File: doc/BRIEF.md
# Interrupt Request Gateway Array

The block sits between raw interrupt request lines and the pending bits of an interrupt controller. It has one gateway per source. Each gateway passes at most one request into the pending array. It then refuses further requests from that source until the handler reports completion. Each source is set to one of two trigger modes:

- **Level mode:** the gateway latches the request level. A request that is still asserted when completion arrives is forwarded again at once.
- **Edge mode:** only rising edges count.

Every gateway is a four-state machine. The state is a busy bit and a held bit (the latched level request):

| State | Meaning |
|---|---|
| `GW_RDY_CLR` | ready, nothing held |
| `GW_RDY_HELD` | ready, a level request is held |
| `GW_BSY_CLR` | forwarded and awaiting completion, nothing held |
| `GW_BSY_HELD` | forwarded and awaiting completion, a level request is held |

The transitions are:

| Transition | From → To | Condition | Pulse |
|---|---|---|---|
| ACCEPT | ready → busy | a request with nonzero priority | yes |
| WAKE | ready and held → busy | priority has just become nonzero | yes |
| RELEASE | busy → ready | completion when there is nothing to re-forward | no |
| REFIRE | busy → busy | completion while held with nonzero priority | yes |

In level mode the held bit follows the sampled request on every edge. In edge mode the held bit keeps its value. The forward is a one-cycle `set_pend_o` pulse toward the controller core. Priority arbitration and register decoding happen elsewhere.

Top module: `irq_gateway`

## Requirements
- R1: After reset every gateway is ready with its held bit clear, and `set_pend_o` is 0 while reset is asserted. A held-bit wake issued right after reset forwards nothing. A level request after reset is accepted.
- R2: The request input is registered once. In edge mode, a rising edge at the register output of a ready gateway with nonzero priority gives exactly one `set_pend_o` pulse on the second clock edge after `req_i` rises, and the gateway becomes busy. All other inputs act on the next clock edge.
- R3: In edge mode a falling request is ignored. A rising edge that arrives while the gateway is busy is dropped and is never forwarded later.
- R4: In level mode a high sampled request on a ready gateway with nonzero priority is forwarded. The held bit copies the sampled request on every edge, whether the gateway is busy or ready.
- R5: With priority zero a ready gateway forwards nothing and stays ready. In level mode it still latches the request in its held bit.
- R6: On completion, a busy gateway with its held bit set and nonzero priority pulses again at once and stays busy. Otherwise it returns to ready.
- R7: When the priority-wake input (priority changed from zero to nonzero) is high, a ready gateway with its held bit set and nonzero priority forwards. This happens even if the request has just dropped.
- R8: A completion strobe on a ready gateway has no effect.
- R9: A completion and a new request in the same cycle are resolved with the completion first. The new request is then accepted, and a pulse appears on that edge.
- R10: A busy gateway never pulses except through REFIRE on completion.
- R11: Sources are independent. The bit positions of all vector ports match source numbers, and several sources may pulse on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_SRC | Raw request per source |
| lvl_mode_i | input | NUM_SRC | 1 = level mode, 0 = edge mode |
| prio_nz_i | input | NUM_SRC | Source priority is nonzero |
| prio_wake_i | input | NUM_SRC | Priority went from zero to nonzero this cycle |
| done_i | input | NUM_SRC | Completion strobe per source |
| set_pend_o | output | NUM_SRC | One-cycle pulse setting the core pending bit |

## Verification
The bench tries the following patterns, each of which separates one behaviour from its neighbours:

- **Edge-mode sequences.** Pulses that rise, fall, and rise again while busy distinguish edge detection from level sampling. They also show that edges arriving while busy are lost.
- **Held level requests across completions.** A level request held through several completions separates REFIRE from RELEASE.
- **A request that drops in the same cycle as completion.** This shows that the held bit, not the live line, drives REFIRE.
- **Zero-priority requests followed by a wake with the line already low.** This separates WAKE from ordinary ACCEPT.
- **Completion coinciding with a fresh edge.** This shows completion-first ordering.
- **Simultaneous activity on two sources.** This shows that the per-source instances are independent.

// File: rtl/irq_gw_pkg.sv
package irq_gw_pkg;

    // bit 1 = busy (forwarded, awaiting completion), bit 0 = held level request
    typedef enum logic [1:0] {
        GW_RDY_CLR  = 2'b00,
        GW_RDY_HELD = 2'b01,
        GW_BSY_CLR  = 2'b10,
        GW_BSY_HELD = 2'b11
    } gw_state_e;

    function automatic gw_state_e gw_encode(input logic busy, input logic held);
        return gw_state_e'({busy, held});
    endfunction

    function automatic logic gw_is_busy(input gw_state_e s);
        return s[1];
    endfunction

    function automatic logic gw_is_held(input gw_state_e s);
        return s[0];
    endfunction

endpackage

// File: rtl/irq_gw_sampler.sv
module irq_gw_sampler #(
    parameter int WIDTH = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] req_i,
    output logic [WIDTH-1:0] cur_o,
    output logic [WIDTH-1:0] prev_o
);

    logic [WIDTH-1:0] cur_q;
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q  <= '0;
            prev_q <= '0;
        end else begin
            cur_q  <= req_i;
            prev_q <= cur_q;
        end
    end

    assign cur_o  = cur_q;
    assign prev_o = prev_q;

endmodule

// File: rtl/irq_gw_cell.sv
module irq_gw_cell
    import irq_gw_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hi_i,
    input  logic prev_i,
    input  logic lvl_i,
    input  logic pnz_i,
    input  logic wake_i,
    input  logic cmp_i,
    output logic set_pend_o
);

    gw_state_e state_q;
    gw_state_e state_d;
    logic      busy_q;
    logic      held_q;
    logic      req_evt;
    logic      held_n;
    logic      busy_n;
    logic      fwd;
    logic      set_pend_q;

    assign busy_q = gw_is_busy(state_q);
    assign held_q = gw_is_held(state_q);

    // next state: completion resolves before a new request
    always_comb begin
        req_evt = lvl_i ? hi_i : (hi_i & ~prev_i);
        held_n  = lvl_i ? hi_i : held_q;
        fwd     = 1'b0;
        busy_n  = 1'b0;
        unique case (state_q)
            GW_RDY_CLR, GW_RDY_HELD: begin
                // ACCEPT or WAKE; a completion here is ignored
                if (pnz_i && (req_evt || (wake_i && held_q))) begin
                    fwd    = 1'b1;
                    busy_n = 1'b1;
                end
            end
            GW_BSY_CLR: begin
                if (cmp_i) begin
                    // RELEASE, then a same-cycle request may be accepted
                    fwd    = pnz_i && req_evt;
                    busy_n = pnz_i && req_evt;
                end else begin
                    busy_n = 1'b1;
                end
            end
            GW_BSY_HELD: begin
                if (cmp_i) begin
                    // REFIRE when priority allows, else RELEASE
                    fwd    = pnz_i;
                    busy_n = pnz_i;
                end else begin
                    busy_n = 1'b1;
                end
            end
            default: begin
                busy_n = 1'b0;
            end
        endcase
        state_d = gw_encode(busy_n, held_n);
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= GW_RDY_CLR;
        end else begin
            state_q <= state_d;
        end
    end

    // output register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            set_pend_q <= 1'b0;
        end else begin
            set_pend_q <= fwd;
        end
    end

    assign set_pend_o = set_pend_q;

endmodule

// File: rtl/irq_gateway.sv
module irq_gateway #(
    parameter int NUM_SRC = 4
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [NUM_SRC-1:0] lvl_mode_i,
    input  logic [NUM_SRC-1:0] prio_nz_i,
    input  logic [NUM_SRC-1:0] prio_wake_i,
    input  logic [NUM_SRC-1:0] done_i,
    output logic [NUM_SRC-1:0] set_pend_o
);

    localparam int LastSrc = NUM_SRC - 1;

    logic [LastSrc:0] req_cur;
    logic [LastSrc:0] req_prev;

    irq_gw_sampler #(.WIDTH(NUM_SRC)) u_sampler (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .req_i  (req_i),
        .cur_o  (req_cur),
        .prev_o (req_prev)
    );

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        irq_gw_cell u_cell (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .hi_i       (req_cur[s]),
            .prev_i     (req_prev[s]),
            .lvl_i      (lvl_mode_i[s]),
            .pnz_i      (prio_nz_i[s]),
            .wake_i     (prio_wake_i[s]),
            .cmp_i      (done_i[s]),
            .set_pend_o (set_pend_o[s])
        );
    end

endmodule

// File: rtl/irq_gw_checker.sv
module irq_gw_checker (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic held,
    input logic hi,
    input logic prev,
    input logic lvl,
    input logic pnz,
    input logic cmp,
    input logic set_pend
);

    assert_pulse_only_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        set_pend |-> busy);

    assert_fall_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !lvl && !held && !(hi && !prev)) |=> !set_pend);

    assert_held_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lvl |=> (held == $past(hi)));

    assert_zero_prio_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !pnz) |=> (!busy && !set_pend));

    assert_refire_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmp && held && pnz) |=> (set_pend && busy));

    assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmp && !pnz) |=> (!busy && !set_pend));

    assert_no_fwd_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cmp) |=> !set_pend);

endmodule

bind irq_gw_cell irq_gw_checker u_chk (
    .clk      (clk_i),
    .rst_n    (rst_ni),
    .busy     (busy_q),
    .held     (held_q),
    .hi       (hi_i),
    .prev     (prev_i),
    .lvl      (lvl_i),
    .pnz      (pnz_i),
    .cmp      (cmp_i),
    .set_pend (set_pend_o)
);

// File: tb/irq_gateway_bench.sv
module irq_gateway_bench;

    localparam int N    = 4;
    localparam int NROW = 34;
    localparam longint WD_NS = 64'd20 * 64'd200000;

    // row fields: [5] req  [4] level  [3] prio nonzero  [2] wake  [1] done  [0] expected pulse (source 0)
    localparam logic [5:0] VEC [NROW] = '{
        6'b001000, // 0  idle
        6'b101000, // 1  req rises (sampled next edge)
        6'b101001, // 2  R2 rising edge forwarded
        6'b001000, // 3  R10 busy
        6'b001010, // 4  R6 release (nothing held)
        6'b101000, // 5
        6'b101001, // 6  R2 second edge accepted
        6'b001000, // 7  R3 falling ignored
        6'b101000, // 8
        6'b001000, // 9  R3 rise while busy dropped
        6'b001010, // 10 R6 release
        6'b001000, // 11 R3 dropped edge never appears
        6'b100000, // 12 R5 zero priority
        6'b000000, // 13 R5 edge with zero priority ignored
        6'b001100, // 14 R7 wake does nothing in edge mode (nothing held)
        6'b111000, // 15 switch to level
        6'b111001, // 16 R4 level accepted
        6'b111000, // 17 R10 busy
        6'b111011, // 18 R6 refire while held
        6'b011000, // 19
        6'b011011, // 20 R6 held bit (last cycle) refires
        6'b011010, // 21 R6 release
        6'b110000, // 22 R5 zero priority level
        6'b110000, // 23 R5 latched, stays ready
        6'b010000, // 24 line drops, held remains
        6'b011101, // 25 R7 wake forwards held request
        6'b011010, // 26 R6 release
        6'b011010, // 27 R8 completion on ready ignored
        6'b101000, // 28 edge mode
        6'b101001, // 29 R2 edge
        6'b001000, // 30
        6'b101000, // 31
        6'b001011, // 32 R9 completion first then new edge
        6'b001010  // 33 R9 release
    };

    logic         clk;
    logic         rst_n;
    logic [N-1:0] req, lvl, pnz, wake, cmp;
    logic [N-1:0] set_pend;
    int           n_chk;
    int           n_fail;
    bit           done_flag;

    irq_gateway #(.NUM_SRC(N)) u_irq_gateway (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .req_i       (req),
        .lvl_mode_i  (lvl),
        .prio_nz_i   (pnz),
        .prio_wake_i (wake),
        .done_i      (cmp),
        .set_pend_o  (set_pend)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_inputs();
        req = '0; lvl = '0; pnz = '0; wake = '0; cmp = '0;
    endtask

    initial begin
        #(WD_NS * 1ns);
        if (!done_flag) begin
            n_fail++;
            $display("FAIL watchdog expired (all requirements)");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] e;
        n_chk = 0;
        n_fail = 0;
        done_flag = 1'b0;
        rst_n = 1'b0;
        clear_inputs();
        repeat (3) @(negedge clk);
        chk("R1 no pulse in reset", set_pend, '0);
        rst_n = 1'b1;

        // table walk on source 0
        for (int k = 0; k < NROW; k++) begin
            req[0]  = VEC[k][5];
            lvl[0]  = VEC[k][4];
            pnz[0]  = VEC[k][3];
            wake[0] = VEC[k][2];
            cmp[0]  = VEC[k][1];
            step();
            e = '0;
            e[0] = VEC[k][0];
            chk($sformatf("table row %0d", k), set_pend, e);
        end

        // R1: reset clears the held bit and makes the gateway ready
        clear_inputs();
        lvl[0] = 1'b1; req[0] = 1'b1;
        repeat (3) step();
        rst_n = 1'b0;
        req[0] = 1'b0;
        step();
        chk("R1 reset output", set_pend, '0);
        rst_n = 1'b1;
        pnz[0] = 1'b1; wake[0] = 1'b1;
        step();
        chk("R1 held clear after reset", set_pend, '0);
        wake[0] = 1'b0; req[0] = 1'b1;
        step();
        chk("R1 request sampling edge", set_pend, '0);
        step();
        chk("R1 ready after reset", set_pend, 4'b0001);

        // R11: independent sources
        clear_inputs();
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        pnz = '1;
        lvl[3] = 1'b1;
        req[2] = 1'b1; req[3] = 1'b1;
        step();
        chk("R11 sample edge", set_pend, '0);
        step();
        chk("R11 two sources pulse together", set_pend, 4'b1100);
        step();
        chk("R11 busy sources quiet", set_pend, '0);
        cmp[2] = 1'b1; cmp[3] = 1'b1;
        step();
        chk("R11 R6 only held level source refires", set_pend, 4'b1000);
        cmp = '0;
        step();
        chk("R11 quiet after refire", set_pend, '0);

        done_flag = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule